// File: doc/BRIEF.md
# Load/Store Register Offset Shifter

This block forms the scaled register offset that a load/store unit adds to, or subtracts from, a base address. It takes the 32-bit value read from the offset register, a 3-bit code that picks the kind of shift, a 6-bit shift count and a carry-in bit. It returns the shifted offset and an error flag. The base addition, the register file read and any update of condition flags are done by its neighbours.

The legal count depends on the kind of shift. Logical left shifts accept 0 to 31. Logical and arithmetic right shifts accept 1 to 32, so a full-width move is possible: it gives zero for the logical case and a copy of the sign bit in every position for the arithmetic case. Rotates accept 1 to 31. The one-bit rotate through carry ignores the count. The block also rejects the program counter (register index 15) as the offset source. On any error the result is forced to zero, so the adder never sees a half-formed value. The unit has no registers: its outputs follow its inputs in the same cycle.

Top module: `offs_shift_unit`

## Requirements
- R1: With shift code 0 (logical left) and a count from 0 to 31, the result is the offset shifted left by the count with zeros filled in, and the error flag is low.
- R2: With shift code 1 (logical right) and a count from 1 to 32, the result is the offset shifted right with zeros filled in; a count of 32 gives zero.
- R3: With shift code 2 (arithmetic right) and a count from 1 to 32, the result is the offset shifted right with copies of bit 31 filled in; a count of 32 gives all bits equal to bit 31.
- R4: With shift code 3 (rotate right) and a count from 1 to 31, the result is the offset rotated right by the count.
- R5: With shift code 4 (rotate through carry) the result is the carry-in in bit 31 and offset bits 31 to 1 in bits 30 to 0, whatever the count.
- R6: An offset register index of 15 raises the error flag and drives the result to zero, for every shift code and count.
- R7: A count outside the legal range of the selected shift code (left: above 31; logical or arithmetic right: 0 or above 32; rotate: 0 or above 31) raises the error flag and drives the result to zero.
- R8: Shift codes 5, 6 and 7 are undefined; they raise the error flag and drive the result to zero.
- R9: When the register index is not 15, the code is 0 to 4 and the count is legal for it, the error flag is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| offset_val | input | 32 | Value read from the offset register |
| shift_kind | input | 3 | Shift code: 0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 rotate through carry |
| shift_amt | input | 6 | Shift count |
| carry_in | input | 1 | Carry bit used by the rotate-through-carry code |
| rm_index | input | 4 | Index of the offset register |
| shifted | output | 32 | Shifted offset, zero on error |
| offs_fault | output | 1 | High when the request is rejected |

## Verification
The block holds no state. A wrong internal decision therefore shows at the ports in the same cycle as the input that causes it: a wrong legality check shows as a wrong error flag, or as a non-zero result where zero is due, and a bad stage of the rotate network corrupts only the counts whose matching bit is set. The bench therefore sweeps every count for each shift code as well as the edges of each legal range, so that each rotate stage and each limit compare is seen both enabled and disabled.

// File: rtl/offs_shift_pkg.sv
// Package: shared encodings for the register offset shifter.
// Assumes a 3-bit shift code; codes above SK_RRX are undefined.
package offs_shift_pkg;

    typedef enum logic [2:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRX = 3'd4
    } shift_kind_e;

endpackage

// File: rtl/offs_range_check.sv
// Module: offs_range_check
// Decides whether a shift request is legal: checks the shift code, the
// count against the range allowed for that code, and the register index
// against the program counter index. Purely combinational.
// Assumes DATA_W fits in AMT_W bits.
module offs_range_check
    import offs_shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 6,
    parameter int IDX_W  = 4,
    parameter int PC_IDX = 15
) (
    input  logic [2:0]       kind,
    input  logic [AMT_W-1:0] amt,
    input  logic [IDX_W-1:0] idx,
    output logic             fault
);

    localparam logic [AMT_W-1:0] AMT_FULL = AMT_W'(DATA_W);
    localparam logic [IDX_W-1:0] PC_CODE  = IDX_W'(PC_IDX);

    logic amt_ok;
    logic pc_hit;

    // Range test per shift code; undefined codes are never legal.
    always_comb begin
        case (kind)
            SK_LSL:  amt_ok = (amt < AMT_FULL);
            SK_LSR,
            SK_ASR:  amt_ok = (amt != '0) && (amt <= AMT_FULL);
            SK_ROR:  amt_ok = (amt != '0) && (amt < AMT_FULL);
            SK_RRX:  amt_ok = 1'b1;
            default: amt_ok = 1'b0;
        endcase
    end

    // Program counter may not supply the offset.
    always_comb pc_hit = (idx == PC_CODE);

    // Combined rejection flag.
    always_comb fault = pc_hit || !amt_ok;

endmodule

// File: rtl/offs_barrel.sv
// Module: offs_barrel
// Shift core: produces the offset for every shift code without any
// legality test. The rotate uses a log-depth network of conditional
// stages; the linear shifts use the native shift operators, which give
// zero or sign fill for a count equal to DATA_W.
// Assumes DATA_W is a power of two and AMT_W > log2(DATA_W).
module offs_barrel
    import offs_shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 6
) (
    input  logic [DATA_W-1:0] data,
    input  logic [2:0]        kind,
    input  logic [AMT_W-1:0]  amt,
    input  logic              cin,
    output logic [DATA_W-1:0] res
);

    localparam int STAGES = $clog2(DATA_W);

    logic [DATA_W-1:0] rot_stage [STAGES+1];
    logic [DATA_W-1:0] lsl_v;
    logic [DATA_W-1:0] lsr_v;
    logic [DATA_W-1:0] asr_v;
    logic [DATA_W-1:0] rrx_v;

    assign rot_stage[0] = data;

    // One rotate stage per count bit, each moving by a power of two.
    for (genvar s = 0; s < STAGES; s++) begin : g_rot
        localparam int SH = 1 << s;
        always_comb
            rot_stage[s+1] = amt[s]
                ? {rot_stage[s][SH-1:0], rot_stage[s][DATA_W-1:SH]}
                : rot_stage[s];
    end

    // Linear shift results for the three shift codes.
    always_comb begin
        lsl_v = data << amt;
        lsr_v = data >> amt;
        asr_v = DATA_W'($signed(data) >>> amt);
        rrx_v = {cin, data[DATA_W-1:1]};
    end

    // Pick the result for the requested code.
    always_comb begin
        case (kind)
            SK_LSL:  res = lsl_v;
            SK_LSR:  res = lsr_v;
            SK_ASR:  res = asr_v;
            SK_ROR:  res = rot_stage[STAGES];
            SK_RRX:  res = rrx_v;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/offs_shift_unit.sv
// Module: offs_shift_unit (top)
// Register offset shifter for the load/store address path. Combines the
// legality check with the shift core and zeroes the result on any error.
// Purely combinational; no clock or reset is needed.
module offs_shift_unit #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 6,
    parameter int IDX_W  = 4,
    parameter int PC_IDX = 15
) (
    input  logic [DATA_W-1:0] offset_val,
    input  logic [2:0]        shift_kind,
    input  logic [AMT_W-1:0]  shift_amt,
    input  logic              carry_in,
    input  logic [IDX_W-1:0]  rm_index,
    output logic [DATA_W-1:0] shifted,
    output logic              offs_fault
);

    logic [DATA_W-1:0] core_res;
    logic              chk_fault;

    offs_range_check #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W),
        .IDX_W  (IDX_W),
        .PC_IDX (PC_IDX)
    ) range_i (
        .kind  (shift_kind),
        .amt   (shift_amt),
        .idx   (rm_index),
        .fault (chk_fault)
    );

    offs_barrel #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W)
    ) core_i (
        .data (offset_val),
        .kind (shift_kind),
        .amt  (shift_amt),
        .cin  (carry_in),
        .res  (core_res)
    );

    // Gate the result to zero whenever the request is rejected.
    always_comb begin
        offs_fault = chk_fault;
        shifted    = chk_fault ? '0 : core_res;
    end

endmodule

// File: rtl/offs_shift_chk.sv
// Module: offs_shift_chk
// Port-level checker for offs_shift_unit. The block is combinational, so
// the checks are immediate assertions evaluated whenever inputs settle;
// each is skipped while any input is still unknown.
module offs_shift_chk #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 6,
    parameter int IDX_W  = 4,
    parameter int PC_IDX = 15
) (
    input logic [DATA_W-1:0] offset_val,
    input logic [2:0]        shift_kind,
    input logic [AMT_W-1:0]  shift_amt,
    input logic              carry_in,
    input logic [IDX_W-1:0]  rm_index,
    input logic [DATA_W-1:0] shifted,
    input logic              offs_fault
);

    localparam logic [AMT_W-1:0] AMT_FULL = AMT_W'(DATA_W);
    localparam logic [IDX_W-1:0] PC_CODE  = IDX_W'(PC_IDX);

    logic known;
    logic idx_ok;

    // Only judge fully defined input combinations.
    always_comb begin
        known  = !$isunknown({offset_val, shift_kind, shift_amt, carry_in, rm_index});
        idx_ok = (rm_index != PC_CODE);
    end

    // Output relations checked at every input change.
    always_comb begin
        if (known) begin
            AST_PC_REJECT: assert (idx_ok || offs_fault) else $error("pc index accepted"); // R6
            AST_FAULT_ZEROES: assert (!offs_fault || shifted == '0) else $error("result not zero on fault"); // R7
            AST_BAD_CODE: assert (shift_kind <= 3'd4 || offs_fault) else $error("undefined code accepted"); // R8
            AST_LSR_FULL: assert (!(idx_ok && shift_kind == 3'd1 && shift_amt == AMT_FULL)
                                  || (!offs_fault && shifted == '0)) else $error("full logical right"); // R2
            AST_ASR_FULL: assert (!(idx_ok && shift_kind == 3'd2 && shift_amt == AMT_FULL)
                                  || (!offs_fault && shifted == {DATA_W{offset_val[DATA_W-1]}})) else $error("full arithmetic right"); // R3
            AST_RRX_FORM: assert (!(idx_ok && shift_kind == 3'd4)
                                  || (!offs_fault && shifted == {carry_in, offset_val[DATA_W-1:1]})) else $error("rotate through carry"); // R5
            AST_LSL_ZERO: assert (!(idx_ok && shift_kind == 3'd0 && shift_amt == '0)
                                  || (!offs_fault && shifted == offset_val)) else $error("left by zero"); // R1
        end
    end

endmodule

bind offs_shift_unit offs_shift_chk #(
    .DATA_W (DATA_W),
    .AMT_W  (AMT_W),
    .IDX_W  (IDX_W),
    .PC_IDX (PC_IDX)
) chk_i (
    .offset_val (offset_val),
    .shift_kind (shift_kind),
    .shift_amt  (shift_amt),
    .carry_in   (carry_in),
    .rm_index   (rm_index),
    .shifted    (shifted),
    .offs_fault (offs_fault)
);

// File: tb/offs_shift_unit_tb_top.sv
// Bench for offs_shift_unit: a vector table walked by one loop, then
// directed sweeps over every count for each shift code.
module offs_shift_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] offset_val = '0;
    logic [2:0]  shift_kind = '0;
    logic [5:0]  shift_amt  = '0;
    logic        carry_in   = 1'b0;
    logic [3:0]  rm_index   = '0;
    logic [31:0] shifted;
    logic        offs_fault;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    offs_shift_unit dut_i (
        .offset_val (offset_val),
        .shift_kind (shift_kind),
        .shift_amt  (shift_amt),
        .carry_in   (carry_in),
        .rm_index   (rm_index),
        .shifted    (shifted),
        .offs_fault (offs_fault)
    );

    // Row: offset, code, count, carry, index, expected result, expected fault, req
    localparam int NV = 21;
    localparam logic [82:0] VEC [NV] = '{
        {32'h9000_0F01, 3'd0, 6'd0,  1'b0, 4'd2,  32'h9000_0F01, 1'b0, 4'd1}, // R1 left by 0
        {32'h9000_0F01, 3'd0, 6'd4,  1'b0, 4'd2,  32'h0000_F010, 1'b0, 4'd1}, // R1
        {32'h9000_0F01, 3'd0, 6'd31, 1'b0, 4'd2,  32'h8000_0000, 1'b0, 4'd1}, // R1 top of range
        {32'h9000_0F01, 3'd0, 6'd32, 1'b0, 4'd2,  32'h0000_0000, 1'b1, 4'd7}, // R7 left by 32
        {32'h9000_0F01, 3'd1, 6'd1,  1'b0, 4'd3,  32'h4800_0780, 1'b0, 4'd2}, // R2
        {32'h9000_0F01, 3'd1, 6'd32, 1'b0, 4'd3,  32'h0000_0000, 1'b0, 4'd2}, // R2 full width
        {32'h9000_0F01, 3'd1, 6'd0,  1'b0, 4'd3,  32'h0000_0000, 1'b1, 4'd7}, // R7 right by 0
        {32'h9000_0F01, 3'd2, 6'd4,  1'b0, 4'd4,  32'hF900_00F0, 1'b0, 4'd3}, // R3
        {32'h9000_0F01, 3'd2, 6'd32, 1'b0, 4'd4,  32'hFFFF_FFFF, 1'b0, 4'd3}, // R3 full width, negative
        {32'h7000_0000, 3'd2, 6'd32, 1'b0, 4'd4,  32'h0000_0000, 1'b0, 4'd3}, // R3 full width, positive
        {32'h9000_0F01, 3'd2, 6'd33, 1'b0, 4'd4,  32'h0000_0000, 1'b1, 4'd7}, // R7 arithmetic by 33
        {32'h9000_0F01, 3'd3, 6'd8,  1'b0, 4'd5,  32'h0190_000F, 1'b0, 4'd4}, // R4
        {32'h9000_0F01, 3'd3, 6'd31, 1'b0, 4'd5,  32'h2000_1E03, 1'b0, 4'd4}, // R4 top of range
        {32'h9000_0F01, 3'd3, 6'd32, 1'b0, 4'd5,  32'h0000_0000, 1'b1, 4'd7}, // R7 rotate by 32
        {32'h9000_0F01, 3'd4, 6'd0,  1'b1, 4'd6,  32'hC800_0780, 1'b0, 4'd5}, // R5 carry set
        {32'h9000_0F01, 3'd4, 6'd17, 1'b0, 4'd6,  32'h4800_0780, 1'b0, 4'd5}, // R5 count ignored
        {32'h9000_0F01, 3'd5, 6'd1,  1'b0, 4'd1,  32'h0000_0000, 1'b1, 4'd8}, // R8
        {32'h9000_0F01, 3'd7, 6'd1,  1'b0, 4'd1,  32'h0000_0000, 1'b1, 4'd8}, // R8
        {32'h9000_0F01, 3'd0, 6'd0,  1'b0, 4'd15, 32'h0000_0000, 1'b1, 4'd6}, // R6
        {32'h9000_0F01, 3'd4, 6'd0,  1'b1, 4'd15, 32'h0000_0000, 1'b1, 4'd6}, // R6 rotate through carry
        {32'h9000_0F01, 3'd3, 6'd4,  1'b0, 4'd14, 32'h1900_00F0, 1'b0, 4'd9}  // R9 index 14 accepted
    };

    // Apply inputs at a rising edge, compare at the following falling edge.
    task automatic apply_check(input logic [31:0] v, input logic [2:0] k,
                               input logic [5:0] a, input logic c, input logic [3:0] ix,
                               input logic [31:0] exp_r, input logic exp_f, input int req);
        @(posedge clk);
        offset_val = v; shift_kind = k; shift_amt = a; carry_in = c; rm_index = ix;
        @(negedge clk);
        n_vec++;
        if (shifted !== exp_r || offs_fault !== exp_f) begin
            n_bad++;
            $display("FAIL R%0d: code %0d count %0d idx %0d: got %h/%b expected %h/%b",
                     req, k, a, ix, shifted, offs_fault, exp_r, exp_f);
        end
    endtask

    initial begin
        // Idle check: zero inputs give zero result, no error (R1 with count 0).
        repeat (2) @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (shifted !== 32'h0 || offs_fault !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: idle got %h/%b expected 00000000/0", shifted, offs_fault);
        end
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++)
            apply_check(VEC[i][82:51], VEC[i][50:48], VEC[i][47:42], VEC[i][41],
                        VEC[i][40:37], VEC[i][36:5], VEC[i][4], int'(VEC[i][3:0]));

        // R1 sweep: single bit walked left across every legal count.
        for (int n = 0; n < 32; n++)
            apply_check(32'h1, 3'd0, 6'(n), 1'b0, 4'd0, 32'h1 << n, 1'b0, 1);
        // R2 sweep: all-ones shifted right by every legal count.
        for (int n = 1; n <= 32; n++)
            apply_check(32'hFFFF_FFFF, 3'd1, 6'(n), 1'b0, 4'd0,
                        (n == 32) ? 32'h0 : (32'hFFFF_FFFF >> n), 1'b0, 2);
        // R3 sweep: sign bit alone, ones fill down to the top n+1 bits.
        for (int n = 1; n <= 32; n++)
            apply_check(32'h8000_0000, 3'd2, 6'(n), 1'b0, 4'd0,
                        (n == 32) ? 32'hFFFF_FFFF : ~(32'hFFFF_FFFF >> (n + 1)), 1'b0, 3);
        // R4 sweep: low bit rotated right by n lands at position 32-n.
        for (int n = 1; n < 32; n++)
            apply_check(32'h1, 3'd3, 6'(n), 1'b0, 4'd0, 32'h1 << (32 - n), 1'b0, 4);
        // R7 sweep: every count above 32 rejected for each linear code.
        for (int n = 33; n < 64; n++)
            apply_check(32'hFFFF_FFFF, 3'(n % 4), 6'(n), 1'b0, 4'd0, 32'h0, 1'b1, 7);
        // R6: program counter rejected across all defined codes.
        for (int k = 0; k < 5; k++)
            apply_check(32'hFFFF_FFFF, 3'(k), 6'd1, 1'b1, 4'd15, 32'h0, 1'b1, 6);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R9: watchdog expired, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule